// File: doc/BRIEF.md
# Function-Coded Integer ALU with Condition Flags

A combinational integer unit that takes a 5-bit function code and two operands, and returns one result word and three condition flags. The result comes from one of five datapaths: an add/subtract path, compares built from the adder flags, a shifter, a low-word multiplier, and a per-bit truth-table unit for the sixteen two-input Boolean functions. There is no clock and no storage. A decode stage in the execute slot of a processor drives the code and the operands, and reads the result in the same cycle.

The flags always come from the adder. The adder runs on every code: bit 0 of the code selects subtract. This holds even when the result is taken from the shifter, the multiplier or the Boolean unit. The width and the implementation style of the adder, the shifter and the multiplier are parameters.

Top module: `opcode_alu`

## Requirements
- R1: Code 0x00 gives Y = A+B and code 0x01 gives Y = A−B, both modulo 2^WIDTH.
- R2: For every code, Z is 1 exactly when the adder output is zero, and N equals the adder output's top bit. The adder output is A+B when code bit 0 is 0 and A−B when it is 1.
- R3: V is set on signed overflow of the adder. For add, this happens when A and B share a sign bit and the sum's sign differs from it. For subtract, it happens when the signs of A and B differ and the difference's sign differs from A's.
- R4: Code 0x05 gives Y = Z, code 0x07 gives Y = N XOR V, and code 0x0D gives Y = (N XOR V) OR Z. The value sits in bit 0 and all upper bits are zero.
- R5: For codes 0x10 to 0x1F, result bit i equals code bit (2·B[i] + A[i]). For example, 0x18 gives AND, 0x1E gives OR, 0x16 gives XOR, 0x19 gives XNOR and 0x1A passes A through.
- R6: Code 0x08 shifts A left and code 0x09 shifts A right, both with zero fill. The shift amount is B[4:0] (the low log2(WIDTH) bits of B), and the higher bits of B have no effect.
- R7: Code 0x0B shifts A right by the same amount and fills the vacated upper bits with A's top bit.
- R8: Code 0x02 gives the low WIDTH bits of the product A·B.
- R9: Codes 0x03, 0x04, 0x06, 0x0A, 0x0C, 0x0E and 0x0F give Y = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_i | input | 5 | Function code |
| a_i | input | WIDTH | First operand; this is the value that is shifted |
| b_i | input | WIDTH | Second operand; its low bits give the shift amount |
| y_o | output | WIDTH | Result word |
| zero_o | output | 1 | Adder output is zero |
| ovf_o | output | 1 | Signed overflow of the adder |
| neg_o | output | 1 | Top bit of the adder output |

## Verification
The bench builds the unit at WIDTH = 32 with the explicit ripple adder, the log-stage shifter and the unrolled shift-add multiplier. With these settings the structural variants are exercised bit by bit, not through the language operators. The bench sweeps all 32 function codes over a grid of sign-boundary and alternating-bit operands. It also sweeps all 32 shift amounts, once with the upper bits of B set, and runs power-of-two products and random pairs. At this width the flag rules meet every overflow corner: the most negative value, the most positive value and the all-ones word.

// File: rtl/opcode_alu_pkg.sv
package opcode_alu_pkg;

   localparam int FN_W = 5;

   typedef enum logic [FN_W-1:0] {
      FN_ADD = 5'h00,
      FN_SUB = 5'h01,
      FN_MUL = 5'h02,
      FN_EQ  = 5'h05,
      FN_LT  = 5'h07,
      FN_SLL = 5'h08,
      FN_SRL = 5'h09,
      FN_SRA = 5'h0B,
      FN_LE  = 5'h0D
   } fn_code_e;

   typedef enum logic [1:0] {
      SH_LEFT        = 2'd0,
      SH_RIGHT_LOG   = 2'd1,
      SH_RIGHT_ARITH = 2'd2
   } shift_kind_e;

   typedef struct packed {
      logic zero;
      logic ovf;
      logic neg;
   } alu_flags_t;

endpackage

// File: rtl/opcode_alu_addsub.sv
module opcode_alu_addsub
   import opcode_alu_pkg::*;
#(
   parameter int WIDTH           = 32,
   parameter bit EXPLICIT_RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output alu_flags_t       flags_o
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   assign b_eff = sub_i ? ~b_i : b_i;

   if (EXPLICIT_RIPPLE) begin : g_ripple
      logic [WIDTH-1:0] carry;
      assign carry[0] = sub_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum_o[i] = a_i[i] ^ b_eff[i] ^ carry[i];
         if (i < WIDTH - 1) begin : g_carry
            assign carry[i+1] = (a_i[i] & b_eff[i]) | (carry[i] & (a_i[i] ^ b_eff[i]));
         end
      end
   end else begin : g_operator
      assign sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};
   end

   assign flags_o.zero = ~|sum_o;
   assign flags_o.neg  = sum_o[MSB];
   assign flags_o.ovf  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

   // Overflow is impossible for mixed-sign add or same-sign subtract (R3)
   always_comb begin
      if (!sub_i && (a_i[MSB] != b_i[MSB])) begin
         p_add_mixed_no_ovf_r3: assert (!flags_o.ovf)
            else $error("R3: overflow flagged on mixed-sign add");
      end
      if (sub_i && (a_i[MSB] == b_i[MSB])) begin
         p_sub_same_no_ovf_r3: assert (!flags_o.ovf)
            else $error("R3: overflow flagged on same-sign subtract");
      end
      if (flags_o.zero) begin
         p_zero_not_neg_r2: assert (!flags_o.neg)
            else $error("R2: zero and negative both set");
      end
   end

endmodule

// File: rtl/opcode_alu_shifter.sv
module opcode_alu_shifter
   import opcode_alu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter bit LOG_STAGES = 1'b1,
   localparam int SHW       = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [SHW-1:0]   amt_i,
   input  shift_kind_e      kind_i,
   output logic [WIDTH-1:0] y_o
);

   localparam int MSB = WIDTH - 1;

   if (LOG_STAGES) begin : g_stages
      logic [WIDTH-1:0] stage [SHW+1];
      logic             fill;
      assign fill     = (kind_i == SH_RIGHT_ARITH) & a_i[MSB];
      assign stage[0] = a_i;
      for (genvar k = 0; k < SHW; k++) begin : g_stage
         localparam int D = 1 << k;
         logic [WIDTH-1:0] moved;
         assign moved = (kind_i == SH_LEFT)
                        ? {stage[k][WIDTH-1-D:0], {D{1'b0}}}
                        : {{D{fill}}, stage[k][WIDTH-1:D]};
         assign stage[k+1] = amt_i[k] ? moved : stage[k];
      end
      assign y_o = stage[SHW];
   end else begin : g_operator
      always_comb begin
         unique case (kind_i)
            SH_LEFT:      y_o = a_i << amt_i;
            SH_RIGHT_LOG: y_o = a_i >> amt_i;
            default:      y_o = $unsigned($signed(a_i) >>> amt_i);
         endcase
      end
   end

   // Zero amount leaves A unchanged (R6); arithmetic fill keeps the sign (R7)
   always_comb begin
      if (amt_i == '0) begin
         p_zero_amount_identity_r6: assert (y_o == a_i)
            else $error("R6: zero shift changed the operand");
      end
      if ((kind_i == SH_RIGHT_ARITH) && a_i[MSB]) begin
         p_arith_keeps_sign_r7: assert (y_o[MSB])
            else $error("R7: arithmetic shift lost the sign");
      end
   end

endmodule

// File: rtl/opcode_alu_bool.sv
module opcode_alu_bool #(
   parameter int WIDTH = 32
) (
   input  logic [3:0]       tt_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] y_o
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign y_o[i] = tt_i[{b_i[i], a_i[i]}];
   end

   // Known truth tables produce the matching word operations (R5)
   always_comb begin
      if (tt_i == 4'h8) begin
         p_table_and_r5: assert (y_o == (a_i & b_i))
            else $error("R5: table 8 is not AND");
      end
      if (tt_i == 4'h6) begin
         p_table_xor_r5: assert (y_o == (a_i ^ b_i))
            else $error("R5: table 6 is not XOR");
      end
   end

endmodule

// File: rtl/opcode_alu_mult.sv
module opcode_alu_mult #(
   parameter int WIDTH    = 32,
   parameter bit UNROLLED = 1'b0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] p_o
);

   if (UNROLLED) begin : g_shift_add
      logic [WIDTH-1:0] acc [WIDTH+1];
      assign acc[0] = '0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_row
         assign acc[i+1] = acc[i] + ({WIDTH{b_i[i]}} & (a_i << i));
      end
      assign p_o = acc[WIDTH];
   end else begin : g_operator
      assign p_o = a_i * b_i;
   end

   // Unit and zero multipliers (R8)
   always_comb begin
      if (b_i == {{(WIDTH-1){1'b0}}, 1'b1}) begin
         p_times_one_r8: assert (p_o == a_i)
            else $error("R8: product by one differs from A");
      end
      if (b_i == '0) begin
         p_times_zero_r8: assert (p_o == '0)
            else $error("R8: product by zero is nonzero");
      end
   end

endmodule

// File: rtl/opcode_alu.sv
module opcode_alu
   import opcode_alu_pkg::*;
#(
   parameter int WIDTH           = 32,
   parameter bit EXPLICIT_RIPPLE = 1'b0,
   parameter bit LOG_SHIFTER     = 1'b1,
   parameter bit UNROLLED_MUL    = 1'b0
) (
   input  logic [4:0]       fn_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] y_o,
   output logic             zero_o,
   output logic             ovf_o,
   output logic             neg_o
);

   localparam int SHW = $clog2(WIDTH);

   if ((WIDTH < 8) || ((WIDTH & (WIDTH - 1)) != 0)) begin : g_bad_width
      $error("opcode_alu: WIDTH must be a power of two of at least 8");
   end

   logic [WIDTH-1:0] sum, sh_res, bool_res, prod;
   alu_flags_t       flags;
   shift_kind_e      sh_kind;
   logic             lt_bit;

   opcode_alu_addsub #(
      .WIDTH          (WIDTH),
      .EXPLICIT_RIPPLE(EXPLICIT_RIPPLE)
   ) u_addsub (
      .a_i    (a_i),
      .b_i    (b_i),
      .sub_i  (fn_i[0]),
      .sum_o  (sum),
      .flags_o(flags)
   );

   always_comb begin
      unique case (fn_i)
         FN_SRL:  sh_kind = SH_RIGHT_LOG;
         FN_SRA:  sh_kind = SH_RIGHT_ARITH;
         default: sh_kind = SH_LEFT;
      endcase
   end

   opcode_alu_shifter #(
      .WIDTH     (WIDTH),
      .LOG_STAGES(LOG_SHIFTER)
   ) u_shifter (
      .a_i   (a_i),
      .amt_i (b_i[SHW-1:0]),
      .kind_i(sh_kind),
      .y_o   (sh_res)
   );

   opcode_alu_bool #(
      .WIDTH(WIDTH)
   ) u_bool (
      .tt_i(fn_i[3:0]),
      .a_i (a_i),
      .b_i (b_i),
      .y_o (bool_res)
   );

   opcode_alu_mult #(
      .WIDTH   (WIDTH),
      .UNROLLED(UNROLLED_MUL)
   ) u_mult (
      .a_i(a_i),
      .b_i(b_i),
      .p_o(prod)
   );

   assign lt_bit = flags.neg ^ flags.ovf;

   always_comb begin
      if (fn_i[4]) begin
         y_o = bool_res;
      end else begin
         unique case (fn_i)
            FN_ADD, FN_SUB:         y_o = sum;
            FN_MUL:                 y_o = prod;
            FN_EQ:                  y_o = {{(WIDTH-1){1'b0}}, flags.zero};
            FN_LT:                  y_o = {{(WIDTH-1){1'b0}}, lt_bit};
            FN_LE:                  y_o = {{(WIDTH-1){1'b0}}, lt_bit | flags.zero};
            FN_SLL, FN_SRL, FN_SRA: y_o = sh_res;
            default:                y_o = '0;
         endcase
      end
   end

   assign zero_o = flags.zero;
   assign ovf_o  = flags.ovf;
   assign neg_o  = flags.neg;

   // Compare results agree with the flags leaving the port (R4); idle codes give zero (R9)
   always_comb begin
      if (fn_i == FN_EQ) begin
         p_eq_follows_zero_r4: assert (y_o == {{(WIDTH-1){1'b0}}, zero_o})
            else $error("R4: equality result disagrees with Z");
      end
      if (fn_i == FN_LT) begin
         p_lt_follows_flags_r4: assert (y_o == {{(WIDTH-1){1'b0}}, neg_o ^ ovf_o})
            else $error("R4: less-than result disagrees with N^V");
      end
      if ((fn_i == FN_LE) && zero_o) begin
         p_le_true_on_zero_r4: assert (y_o == {{(WIDTH-1){1'b0}}, 1'b1})
            else $error("R4: less-or-equal false on equal operands");
      end
      if (fn_i inside {5'h03, 5'h04, 5'h06, 5'h0A, 5'h0C, 5'h0E, 5'h0F}) begin
         p_idle_code_zero_r9: assert (y_o == '0)
            else $error("R9: unassigned code gave nonzero result");
      end
   end

endmodule

// File: tb/opcode_alu_bench.sv
module opcode_alu_bench;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 32;

   logic         clk = 1'b0;
   logic [4:0]   fn;
   logic [W-1:0] a, b, y;
   logic         z, v, n;
   int           checks   = 0;
   int           failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   opcode_alu #(
      .WIDTH          (W),
      .EXPLICIT_RIPPLE(1'b1),
      .LOG_SHIFTER    (1'b1),
      .UNROLLED_MUL   (1'b1)
   ) u_opcode_alu (
      .fn_i  (fn),
      .a_i   (a),
      .b_i   (b),
      .y_o   (y),
      .zero_o(z),
      .ovf_o (v),
      .neg_o (n)
   );

   function automatic logic [W-1:0] adder_out(logic [4:0] f, logic [W-1:0] x, logic [W-1:0] yv);
      return f[0] ? x - yv : x + yv;
   endfunction

   function automatic logic exp_ovf(logic [4:0] f, logic [W-1:0] x, logic [W-1:0] yv);
      longint sx = longint'($signed(x));
      longint sy = longint'($signed(yv));
      longint r  = f[0] ? sx - sy : sx + sy;
      return (r > 64'sd2147483647) || (r < -64'sd2147483648);
   endfunction

   function automatic logic [W-1:0] exp_y(logic [4:0] f, logic [W-1:0] x, logic [W-1:0] yv);
      logic [W-1:0] s  = adder_out(f, x, yv);
      logic         ez = (s == '0);
      logic         lt = ($signed(x) < $signed(yv));
      int           sh = int'(yv[4:0]);
      if (f[4])
         return (~x & ~yv & {W{f[0]}}) | (x & ~yv & {W{f[1]}})
              | (~x & yv & {W{f[2]}})  | (x & yv & {W{f[3]}});
      case (f)
         5'h00, 5'h01: return s;
         5'h02:        return x * yv;
         5'h05:        return {31'b0, ez};
         5'h07:        return {31'b0, lt};
         5'h0D:        return {31'b0, lt | ez};
         5'h08:        return x << sh;
         5'h09:        return x >> sh;
         5'h0B:        return $unsigned($signed(x) >>> sh);
         default:      return '0;
      endcase
   endfunction

   function automatic string req_of(logic [4:0] f);
      if (f[4]) return "R5";
      case (f)
         5'h00, 5'h01:        return "R1";
         5'h02:               return "R8";
         5'h05, 5'h07, 5'h0D: return "R4";
         5'h08, 5'h09:        return "R6";
         5'h0B:               return "R7";
         default:             return "R9";
      endcase
   endfunction

   task automatic check(string req, string what, logic [W-1:0] got, logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s fn=%h a=%h b=%h actual=%h expected=%h", req, what, fn, a, b, got, exp);
      end
   endtask

   task automatic apply(logic [4:0] f, logic [W-1:0] x, logic [W-1:0] yv);
      logic [W-1:0] s;
      @(negedge clk);
      fn = f; a = x; b = yv;
      #1;
      s = adder_out(f, x, yv);
      check(req_of(f), "Y", y, exp_y(f, x, yv));
      check("R2", "Z", {31'b0, z}, {31'b0, s == '0});
      check("R2", "N", {31'b0, n}, {31'b0, s[W-1]});
      check("R3", "V", {31'b0, v}, {31'b0, exp_ovf(f, x, yv)});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [W-1:0] pats [10] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h5555_5555, 32'hAAAA_AAAA,
                                  32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_1234, 32'hFFFF_1234, 32'h3};
      fn = '0; a = '0; b = '0;
      // Quiescent state: zero operands add to zero with Z set (R1, R2)
      apply(5'h00, '0, '0);
      // Every code over the operand grid (R1..R9)
      for (int f = 0; f < 32; f++)
         for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
               apply(5'(f), pats[i], pats[j]);
      // Signed compares around zero (R4)
      for (int i = -6; i <= 6; i++)
         for (int j = -6; j <= 6; j++) begin
            apply(5'h05, W'(i), W'(j));
            apply(5'h07, W'(i), W'(j));
            apply(5'h0D, W'(i), W'(j));
         end
      // All shift amounts, with the upper bits of B set as well (R6, R7)
      for (int s = 0; s < 32; s++)
         for (int i = 0; i < 10; i++) begin
            apply(5'h08, pats[i], W'(s));
            apply(5'h09, pats[i], W'(s));
            apply(5'h0B, pats[i], W'(s));
            apply(5'h08, pats[i], W'(s) | 32'hFFFF_FFE0);
            apply(5'h09, pats[i], W'(s) | 32'hABCD_E0E0);
            apply(5'h0B, pats[i], W'(s) | 32'h8000_0020);
         end
      // Power-of-two and near products (R8)
      for (int i = 0; i < 32; i++) begin
         apply(5'h02, 32'h1 << i, 32'h1);
         apply(5'h02, 32'hFFFF_FFFF, 32'h1 << i);
         apply(5'h02, 32'h3 << i, 32'h3);
      end
      // Overflow boundaries (R3)
      apply(5'h00, 32'h7FFF_FFFF, 32'h1);
      apply(5'h01, 32'h8000_0000, 32'h1);
      apply(5'h01, 32'h0, 32'h8000_0000);
      apply(5'h00, 32'h8000_0000, 32'h8000_0000);
      // Random pairs over all codes
      for (int r = 0; r < 3000; r++)
         apply(5'($urandom_range(31)), $urandom, $urandom);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule